// File: doc/BRIEF.md
# Segment Base-Bound Translator

This block turns an effective address into a physical address by using a small table of segment descriptors. Each descriptor holds a base and a bound. The block chooses a descriptor in one of two ways. In explicit mode the high bits of the effective address name the descriptor. In implied mode the kind of access names it: one descriptor serves instruction fetches and another serves data accesses. The block adds the chosen base to the segment offset. It then checks that the sum stays strictly below the chosen bound and does not carry past the physical address width.

Translation is combinational and ends in one registered output stage. That stage carries a valid flag, the physical address and a legality flag. The descriptor table is privileged state. A write port loads it, but only while the supervisor input is high. A write attempted without supervisor rights changes nothing in the table and raises a sticky error flag. Only reset clears that flag.

Top module: `segxlate_top`

## Requirements
- R1: After reset, outValid, accessOk and privErr are 0, and every descriptor holds base 0 and bound 0, so any translation reports a violation.
- R2: When selMode is 0 (explicit), the descriptor index is effAddr[15:13]. The offset is effAddr[12:0], zero-extended, and physAddr is that descriptor's base plus the offset, truncated to 16 bits.
- R3: accessOk is 1 only when the 17-bit sum of base and offset has no carry out of bit 15 and its low 16 bits are strictly less than the bound. A sum equal to the bound is a violation.
- R4: When selMode is 1 (implied), descriptor 0 is used when isFetch is 1 and descriptor 1 when isFetch is 0. The offset is the whole 16-bit effAddr.
- R5: A write with wrEn=1 and supervisor=1 loads wrBase and wrBound into descriptor wrIdx at the clock edge. Translations issued from the next cycle on use the new values.
- R6: A write with wrEn=1 and supervisor=0 leaves the table unchanged and sets privErr, which stays 1 until reset.
- R7: outValid equals inValid one cycle earlier. When inValid is 0, physAddr and accessOk keep their previous values.
- R8: When a translation and a supervisor write to the same descriptor fall in one cycle, the translation uses the descriptor's contents from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| supervisor | input | 1 | Privilege level of the current requester |
| wrEn | input | 1 | Table write request |
| wrIdx | input | 3 | Descriptor to write |
| wrBase | input | 16 | Base value to load |
| wrBound | input | 16 | Bound value to load |
| selMode | input | 1 | 0 = explicit segment field, 1 = implied by access kind |
| inValid | input | 1 | Translation request |
| isFetch | input | 1 | 1 = instruction fetch, 0 = data access |
| effAddr | input | 16 | Effective address |
| outValid | output | 1 | Registered result valid |
| physAddr | output | 16 | Translated physical address |
| accessOk | output | 1 | 1 = within bound, 0 = violation |
| privErr | output | 1 | Sticky flag for a rejected table write |

## Verification
A table write and a translation can both occur in one cycle. They can also target the same descriptor. To provoke this, the bench raises inValid in the cycle that a supervisor write to the translated entry is issued. The scoreboard then expects a result computed from the old descriptor. A second translation in the next cycle must show the new base and bound. A rejected user-mode write is issued in the same way, and the next translation must still use the unchanged descriptor.

// File: rtl/segxlate_pkg.sv
package segxlate_pkg;

  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic tblWrEn;     // accepted (privileged) descriptor write
    logic stageLoad;   // load the output stage with a new translation
    logic fullOffset;  // implied mode: whole effective address is the offset
  } segCtl_t;

  typedef enum logic {
    SEL_EXPLICIT = 1'b0,
    SEL_IMPLIED  = 1'b1
  } segSel_e;

endpackage

// File: rtl/segxlate_ctrl.sv
module segxlate_ctrl
  import segxlate_pkg::*;
#(
  parameter int ENTRY_CNT = 8,
  localparam int SEL_W = $clog2(ENTRY_CNT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             supervisor,
  input  logic             wrEn,
  input  logic             selMode,
  input  logic             inValid,
  input  logic             isFetch,
  input  logic [SEL_W-1:0] segField,
  output segCtl_t          ctl,
  output logic [SEL_W-1:0] selIdx,
  output logic             privErr
);

  localparam logic [SEL_W-1:0] FETCH_IDX = SEL_W'(0);
  localparam logic [SEL_W-1:0] DATA_IDX  = SEL_W'(1);

  segSel_e selKind;
  logic    privErrSet;

  assign selKind = segSel_e'(selMode);

  always_comb begin
    ctl            = '0;
    ctl.tblWrEn    = wrEn && supervisor;
    ctl.stageLoad  = inValid;
    ctl.fullOffset = (selKind == SEL_IMPLIED);
  end

  // Descriptor choice: explicit field or access kind
  always_comb begin
    if (selKind == SEL_IMPLIED) selIdx = isFetch ? FETCH_IDX : DATA_IDX;
    else                        selIdx = segField;
  end

  assign privErrSet = wrEn && !supervisor;

  always_ff @(posedge clk) begin
    if (!rstN)           privErr <= 1'b0;
    else if (privErrSet) privErr <= 1'b1;
  end

  // R6: error flag never drops without reset
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    privErr |=> privErr);

endmodule

// File: rtl/segxlate_datapath.sv
module segxlate_datapath
  import segxlate_pkg::*;
#(
  parameter int ENTRY_CNT = 8,
  parameter int ADDR_W    = 16,
  parameter int PHYS_W    = 16,
  localparam int SEL_W    = $clog2(ENTRY_CNT),
  localparam int OFF_W    = ADDR_W - SEL_W,
  localparam int SUM_W    = ((ADDR_W > PHYS_W) ? ADDR_W : PHYS_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  segCtl_t           ctl,
  input  logic [SEL_W-1:0]  selIdx,
  input  logic [SEL_W-1:0]  wrIdx,
  input  logic [PHYS_W-1:0] wrBase,
  input  logic [PHYS_W-1:0] wrBound,
  input  logic [ADDR_W-1:0] effAddr,
  output logic              outValid,
  output logic [PHYS_W-1:0] physAddr,
  output logic              accessOk
);

  logic [ENTRY_CNT-1:0][PHYS_W-1:0] baseTbl;
  logic [ENTRY_CNT-1:0][PHYS_W-1:0] boundTbl;
  logic [PHYS_W-1:0] selBase;
  logic [PHYS_W-1:0] selBound;
  logic [SUM_W-1:0]  offsetExt;
  logic [SUM_W-1:0]  sum;
  logic              carryOut;
  logic              legal;

  // Descriptor storage, one register pair per entry
  for (genvar g = 0; g < ENTRY_CNT; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseTbl[g]  <= '0;
        boundTbl[g] <= '0;
      end else if (ctl.tblWrEn && (wrIdx == SEL_W'(g))) begin
        baseTbl[g]  <= wrBase;
        boundTbl[g] <= wrBound;
      end
    end
  end

  assign selBase  = baseTbl[selIdx];
  assign selBound = boundTbl[selIdx];

  always_comb begin
    offsetExt = '0;
    if (ctl.fullOffset) offsetExt[ADDR_W-1:0] = effAddr;
    else                offsetExt[OFF_W-1:0]  = effAddr[OFF_W-1:0];
  end

  assign sum      = SUM_W'(selBase) + offsetExt;
  assign carryOut = |sum[SUM_W-1:PHYS_W];
  assign legal    = !carryOut && (sum[PHYS_W-1:0] < selBound);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      physAddr <= '0;
      accessOk <= 1'b0;
    end else begin
      outValid <= ctl.stageLoad;
      if (ctl.stageLoad) begin
        physAddr <= sum[PHYS_W-1:0];
        accessOk <= legal;
      end
    end
  end

  // R7: valid follows the request by one cycle
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stageLoad |=> outValid);
  a_r7_idle_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.stageLoad |=> !outValid);
  // R7: result holds while no request
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.stageLoad |=> ($stable(physAddr) && $stable(accessOk)));
  // R6: table changes only through an accepted write
  a_r6_table_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.tblWrEn |=> ($stable(baseTbl) && $stable(boundTbl)));
  // R3: a legal result always lies below the bound it was checked against
  a_r3_ok_below_bound: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stageLoad |=> (!accessOk || (physAddr < $past(selBound))));

endmodule

// File: rtl/segxlate_top.sv
module segxlate_top
  import segxlate_pkg::*;
#(
  parameter int ENTRY_CNT = 8,
  parameter int ADDR_W    = 16,
  parameter int PHYS_W    = 16,
  localparam int SEL_W    = $clog2(ENTRY_CNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supervisor,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrIdx,
  input  logic [PHYS_W-1:0] wrBase,
  input  logic [PHYS_W-1:0] wrBound,
  input  logic              selMode,
  input  logic              inValid,
  input  logic              isFetch,
  input  logic [ADDR_W-1:0] effAddr,
  output logic              outValid,
  output logic [PHYS_W-1:0] physAddr,
  output logic              accessOk,
  output logic              privErr
);

  segCtl_t          ctl;
  logic [SEL_W-1:0] selIdx;

  segxlate_ctrl #(.ENTRY_CNT(ENTRY_CNT)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .supervisor(supervisor),
    .wrEn      (wrEn),
    .selMode   (selMode),
    .inValid   (inValid),
    .isFetch   (isFetch),
    .segField  (effAddr[ADDR_W-1 -: SEL_W]),
    .ctl       (ctl),
    .selIdx    (selIdx),
    .privErr   (privErr)
  );

  segxlate_datapath #(
    .ENTRY_CNT(ENTRY_CNT),
    .ADDR_W   (ADDR_W),
    .PHYS_W   (PHYS_W)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .selIdx  (selIdx),
    .wrIdx   (wrIdx),
    .wrBase  (wrBase),
    .wrBound (wrBound),
    .effAddr (effAddr),
    .outValid(outValid),
    .physAddr(physAddr),
    .accessOk(accessOk)
  );

  // R6: a user-mode write raises the error flag next cycle
  a_r6_flag_on_user_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !supervisor) |=> privErr);

endmodule

// File: tb/test_segxlate_top.sv
module test_segxlate_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        supervisor, wrEn, selMode, inValid, isFetch;
  logic [2:0]  wrIdx;
  logic [15:0] wrBase, wrBound, effAddr;
  logic        outValid, accessOk, privErr;
  logic [15:0] physAddr;

  int checks = 0;
  int errors = 0;

  logic [15:0] mBase  [8];
  logic [15:0] mBound [8];
  logic [16:0] expQ [$];   // {ok, pa}
  string       tagQ [$];
  logic [15:0] lastPa;
  logic        lastOk;

  always #5 clk = ~clk;

  segxlate_top i_segxlate_top (
    .clk(clk), .rstN(rstN), .supervisor(supervisor), .wrEn(wrEn),
    .wrIdx(wrIdx), .wrBase(wrBase), .wrBound(wrBound), .selMode(selMode),
    .inValid(inValid), .isFetch(isFetch), .effAddr(effAddr),
    .outValid(outValid), .physAddr(physAddr), .accessOk(accessOk),
    .privErr(privErr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected result from the requirements (R2, R3, R4)
  function automatic logic [16:0] model(input logic mode, input logic fetch,
                                        input logic [15:0] addr);
    int unsigned idx;
    logic [16:0] s;
    logic ok;
    if (mode) begin
      idx = fetch ? 0 : 1;
      s = {1'b0, mBase[idx]} + {1'b0, addr};
    end else begin
      idx = int'(addr[15:13]);
      s = {1'b0, mBase[idx]} + {4'b0, addr[12:0]};
    end
    ok = !s[16] && (s[15:0] < mBound[idx]);
    return {ok, s[15:0]};
  endfunction

  // Driver: one cycle of stimulus, expectation pushed from pre-edge table
  task automatic drive(input logic doWr, input logic sup, input logic [2:0] idx,
                       input logic [15:0] b, input logic [15:0] bd,
                       input logic doXl, input logic mode, input logic fetch,
                       input logic [15:0] addr, input string tag);
    @(negedge clk);
    wrEn = doWr; supervisor = sup; wrIdx = idx; wrBase = b; wrBound = bd;
    inValid = doXl; selMode = mode; isFetch = fetch; effAddr = addr;
    if (doXl) begin
      expQ.push_back(model(mode, fetch, addr));
      tagQ.push_back(tag);
    end
    @(posedge clk); #1;
    if (doWr && sup) begin
      mBase[idx] = b;
      mBound[idx] = bd;
    end
  endtask

  task automatic xl(input logic mode, input logic fetch, input logic [15:0] addr,
                    input string tag);
    drive(1'b0, 1'b0, 3'd0, 16'h0, 16'h0, 1'b1, mode, fetch, addr, tag);
  endtask

  task automatic wr(input logic sup, input logic [2:0] idx, input logic [15:0] b,
                    input logic [15:0] bd);
    drive(1'b1, sup, idx, b, bd, 1'b0, 1'b0, 1'b0, 16'h0, "");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wrEn = 1'b0; inValid = 1'b0; supervisor = 1'b0;
    end
  endtask

  // Monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (rstN === 1'b1 && outValid === 1'b1) begin
      if (expQ.size() == 0) begin
        chk("R7 unexpected outValid", 32'd1, 32'd0);
      end else begin
        logic [16:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk({t, " physAddr"}, {16'h0, physAddr}, {16'h0, e[15:0]});
        chk({t, " accessOk"}, {31'h0, accessOk}, {31'h0, e[16]});
        lastPa = e[15:0];
        lastOk = e[16];
      end
    end
  end

  initial begin
    #(20000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mBase[i] = '0; mBound[i] = '0; end
    rstN = 1'b0; wrEn = 0; supervisor = 0; wrIdx = 0; wrBase = 0; wrBound = 0;
    selMode = 0; inValid = 0; isFetch = 0; effAddr = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 outValid", {31'h0, outValid}, 0);
    chk("R1 accessOk", {31'h0, accessOk}, 0);
    chk("R1 privErr",  {31'h0, privErr}, 0);
    rstN = 1'b1;
    // R1: empty table violates
    xl(1'b0, 1'b0, 16'h2005, "R1 empty table");
    xl(1'b1, 1'b1, 16'h0040, "R1 empty table implied");
    idle(2);

    // R5: privileged loads
    wr(1'b1, 3'd1, 16'h4000, 16'h5000);
    wr(1'b1, 3'd5, 16'h1000, 16'h2FFF);
    wr(1'b1, 3'd0, 16'h8000, 16'h9000);
    wr(1'b1, 3'd7, 16'hF000, 16'hFFFF);

    // R2: explicit selection, back to back
    xl(1'b0, 1'b0, 16'h2010, "R2 entry1");
    xl(1'b0, 1'b1, 16'hBFFE, "R2 entry5 in range");
    xl(1'b0, 1'b0, 16'h0123, "R2 entry0");
    // R3: sum equal to bound, and carry out
    xl(1'b0, 1'b0, 16'hBFFF, "R3 equal bound");
    xl(1'b0, 1'b0, 16'hF800, "R3 carry out");
    // R4: implied selection
    xl(1'b1, 1'b1, 16'h0123, "R4 fetch entry0");
    xl(1'b1, 1'b0, 16'h0FFF, "R4 data entry1");
    xl(1'b1, 1'b0, 16'h1000, "R4 data at bound");
    xl(1'b1, 1'b1, 16'hFFFF, "R4 fetch carry");
    xl(1'b1, 1'b0, 16'hE000, "R4 high bits not an index");
    idle(3);
    // R7: idle holds result and drops valid
    chk("R7 idle outValid", {31'h0, outValid}, 0);
    chk("R7 hold physAddr", {16'h0, physAddr}, {16'h0, lastPa});
    chk("R7 hold accessOk", {31'h0, accessOk}, {31'h0, lastOk});

    // R6: rejected user write
    chk("R6 privErr before", {31'h0, privErr}, 0);
    wr(1'b0, 3'd1, 16'h0000, 16'hFFFF);
    chk("R6 privErr set", {31'h0, privErr}, 1);
    xl(1'b1, 1'b0, 16'h0010, "R6 entry1 unchanged");
    xl(1'b0, 1'b0, 16'h2020, "R6 entry1 unchanged explicit");

    // R8: write and translate same descriptor in one cycle
    drive(1'b1, 1'b1, 3'd2, 16'h0100, 16'h0200, 1'b1, 1'b0, 1'b0, 16'h4020,
          "R8 old contents");
    xl(1'b0, 1'b0, 16'h4020, "R8 new contents");
    xl(1'b0, 1'b0, 16'h4100, "R5 new bound equality");
    idle(3);

    // R6: sticky through idle and accepted writes
    wr(1'b1, 3'd3, 16'h0000, 16'h0010);
    idle(4);
    chk("R6 privErr sticky", {31'h0, privErr}, 1);
    xl(1'b0, 1'b0, 16'h600F, "R5 entry3 last legal");
    idle(3);
    chk("R7 queue drained", expQ.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule